// File: doc/BRIEF.md
# Memory Fence Ordering Unit

This block sits between one processor's load/store issue port and the memory system. Loads and stores pass straight through in the cycle they are presented. Each one gets a tag, and memory may acknowledge the tags in any order. While no fence is present, requests are not ordered against each other and no stall is added.

A fence request is never sent to memory. It waits at the input until the earlier operations it covers have all been acknowledged, and it retires in that same cycle. The input is strictly in order, so a waiting fence also holds back every later request. Four fence flavours are supported: a full fence, a fence that covers only loads, a fence that covers only stores, and a fence that covers only the operations whose address falls in the same region as the fence's own address.

A typical use is a producer that writes a data word and then a queue tail pointer. A store fence placed between the two stores keeps the pointer store off the memory port until the data store has been acknowledged.

Top module: `fence_order_unit`

## Requirements
- R1: After reset, `ld_count` and `st_count` are 0 and `mem_valid` is low. A load request is accepted at once when `mem_ready` is high.
- R2: A load (op 0) or store (op 1) with a free slot appears on `mem_valid` in the same cycle, with the address unchanged and `mem_store` set for stores. Its `mem_tag` is below 15 and is not the tag of any operation still outstanding. `ld_count` or `st_count` rises by one on the next cycle.
- R3: At most 15 operations are outstanding. With 15 outstanding, loads and stores are not accepted and `mem_valid` stays low.
- R4: A completion whose tag is outstanding lowers the matching class count by one on the next cycle. A completion whose tag is not outstanding changes nothing.
- R5: A full fence (op 2; ops 6 and 7 behave the same) is accepted only when both counts are 0. No fence ever drives `mem_valid`.
- R6: A load fence (op 3) waits only until `ld_count` is 0. Outstanding stores do not hold it.
- R7: A store fence (op 4) waits only until `st_count` is 0. Outstanding loads do not hold it.
- R8: A region fence (op 5) waits only until no outstanding operation has address bits [15:12] equal to bits [15:12] of the fence's address.
- R9: Requests with no fence between them are never stalled. A load or store is accepted whenever `mem_ready` is high and fewer than 15 operations are outstanding, whatever is outstanding.
- R10: A fence retires in the cycle its condition first holds. No request behind it reaches `mem_valid` while an earlier operation that the fence covers is still unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 3 | 0 load, 1 store, 2 full fence, 3 load fence, 4 store fence, 5 region fence |
| req_addr | input | 16 | Request address; bits [15:12] select the region |
| mem_valid | output | 1 | Operation offered to memory |
| mem_ready | input | 1 | Memory takes the offered operation |
| mem_store | output | 1 | Offered operation is a store |
| mem_addr | output | 16 | Offered address |
| mem_tag | output | 4 | Tag that memory returns on completion |
| cpl_valid | input | 1 | Completion present |
| cpl_tag | input | 4 | Tag being acknowledged |
| ld_count | output | 4 | Outstanding loads |
| st_count | output | 4 | Outstanding stores |

## Verification
If the slot table holds a wrong entry, the fault shows on `ld_count` or `st_count` one cycle after the issue or completion that caused it. It also shows as a fence accepted or refused in the same cycle the fence is presented.

A fault in scope decoding shows at once as a refused or accepted `req_ready` when a fence is presented against a mix of outstanding loads, stores and regions. A fault in tag allocation shows as a `mem_tag` that repeats the tag of an outstanding operation.

// File: rtl/fence_pkg.sv
package fence_pkg;

  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_STORE     = 3'd1,
    OP_FENCE_ALL = 3'd2,
    OP_FENCE_LD  = 3'd3,
    OP_FENCE_ST  = 3'd4,
    OP_FENCE_RGN = 3'd5,
    OP_RSV6      = 3'd6,
    OP_RSV7      = 3'd7
  } op_e;

  function automatic logic is_mem_op(op_e op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  // A fence may retire once every class it covers is idle.
  function automatic logic scope_clear(op_e op, logic ld_idle, logic st_idle,
                                       logic rgn_idle);
    case (op)
      OP_FENCE_LD:  return ld_idle;
      OP_FENCE_ST:  return st_idle;
      OP_FENCE_RGN: return rgn_idle;
      default:      return ld_idle && st_idle;
    endcase
  endfunction

endpackage

// File: rtl/fence_slot_table.sv
module fence_slot_table #(
  parameter int SLOTS = 15,
  parameter int TW    = 4,
  parameter int CW    = 4,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          alloc_store,
  input  logic [RW-1:0] alloc_rgn,
  input  logic          free_en,
  input  logic [TW-1:0] free_tag,
  input  logic [RW-1:0] query_rgn,
  output logic [TW-1:0] alloc_tag,
  output logic          have_free,
  output logic          free_hit,
  output logic [CW-1:0] ld_cnt,
  output logic [CW-1:0] st_cnt,
  output logic          rgn_busy
);

  logic          vld [SLOTS];
  logic          sto [SLOTS];
  logic [RW-1:0] rgn [SLOTS];

  // Lowest free slot index.
  always_comb begin
    alloc_tag = '0;
    have_free = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        alloc_tag = TW'(i);
        have_free = 1'b1;
      end
    end
  end

  // Per-class occupancy and the region match for region fences.
  always_comb begin
    ld_cnt   = '0;
    st_cnt   = '0;
    rgn_busy = 1'b0;
    free_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && sto[i])  st_cnt = st_cnt + CW'(1);
      if (vld[i] && !sto[i]) ld_cnt = ld_cnt + CW'(1);
      if (vld[i] && rgn[i] == query_rgn) rgn_busy = 1'b1;
      if (vld[i] && free_en && free_tag == TW'(i)) free_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        vld[i] <= 1'b0;
        sto[i] <= 1'b0;
        rgn[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (free_en && free_tag == TW'(i)) vld[i] <= 1'b0;
        if (alloc_en && alloc_tag == TW'(i)) begin
          vld[i] <= 1'b1;
          sto[i] <= alloc_store;
          rgn[i] <= alloc_rgn;
        end
      end
    end
  end

  // R2: a freshly allocated slot is never one already in use.
  p_alloc_free_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> have_free);

endmodule

// File: rtl/fence_gate.sv
module fence_gate
  import fence_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          req_valid,
  input  op_e           op,
  input  logic [CW-1:0] ld_cnt,
  input  logic [CW-1:0] st_cnt,
  input  logic          rgn_busy,
  input  logic          have_free,
  input  logic          mem_ready,
  output logic          req_ready,
  output logic          issue_valid,
  output logic          fence_done
);

  logic mem_op;
  logic clear;

  assign mem_op      = is_mem_op(op);
  assign clear       = scope_clear(op, ld_cnt == '0, st_cnt == '0, !rgn_busy);
  assign issue_valid = req_valid && mem_op && have_free;
  assign req_ready   = mem_op ? (mem_ready && have_free) : clear;
  assign fence_done  = req_valid && !mem_op && clear;

endmodule

// File: rtl/fence_order_unit.sv
module fence_order_unit
  import fence_pkg::*;
#(
  parameter int AW      = 16,
  parameter int RGN_LSB = 12,
  parameter int MAX_OUT = 15,
  parameter int TW      = $clog2(MAX_OUT),
  parameter int CW      = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_store,
  output logic [AW-1:0] mem_addr,
  output logic [TW-1:0] mem_tag,
  input  logic          cpl_valid,
  input  logic [TW-1:0] cpl_tag,
  output logic [CW-1:0] ld_count,
  output logic [CW-1:0] st_count
);

  localparam int RW = AW - RGN_LSB;

  op_e           op;
  logic [RW-1:0] req_rgn;
  logic          have_free;
  logic          free_hit;
  logic          rgn_busy;
  logic          issue_valid;
  logic          issue_fire;
  logic          fence_done;
  logic [CW:0]   total;

  assign op         = op_e'(req_op);
  assign req_rgn    = req_addr[AW-1:RGN_LSB];
  assign issue_fire = issue_valid && mem_ready;
  assign mem_valid  = issue_valid;
  assign mem_store  = (op == OP_STORE);
  assign mem_addr   = req_addr;
  assign total      = {1'b0, ld_count} + {1'b0, st_count};

  fence_slot_table #(.SLOTS(MAX_OUT), .TW(TW), .CW(CW), .RW(RW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (issue_fire),
    .alloc_store(op == OP_STORE),
    .alloc_rgn  (req_rgn),
    .free_en    (cpl_valid),
    .free_tag   (cpl_tag),
    .query_rgn  (req_rgn),
    .alloc_tag  (mem_tag),
    .have_free  (have_free),
    .free_hit   (free_hit),
    .ld_cnt     (ld_count),
    .st_cnt     (st_count),
    .rgn_busy   (rgn_busy)
  );

  fence_gate #(.CW(CW)) u_gate (
    .req_valid  (req_valid),
    .op         (op),
    .ld_cnt     (ld_count),
    .st_cnt     (st_count),
    .rgn_busy   (rgn_busy),
    .have_free  (have_free),
    .mem_ready  (mem_ready),
    .req_ready  (req_ready),
    .issue_valid(issue_valid),
    .fence_done (fence_done)
  );

  p_fence_not_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (req_op == 3'd0 || req_op == 3'd1));

  p_full_fence_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && req_op == 3'd2) |-> (ld_count == '0 && st_count == '0));

  p_load_fence_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && req_op == 3'd3) |-> ld_count == '0);

  p_store_fence_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_done && req_op == 3'd4) |-> st_count == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    total <= (CW+1)'(MAX_OUT));

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !free_hit) |=> total == $past(total) + 1'b1);

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_hit && !issue_fire) |=> total == $past(total) - 1'b1);

  p_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op <= 3'd1 && mem_ready && total < (CW+1)'(MAX_OUT))
      |-> req_ready);

endmodule

// File: tb/fence_order_unit_test.sv
module fence_order_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_op;
  logic [15:0] req_addr;
  logic        mem_valid;
  logic        mem_ready;
  logic        mem_store;
  logic [15:0] mem_addr;
  logic [3:0]  mem_tag;
  logic        cpl_valid;
  logic [3:0]  cpl_tag;
  logic [3:0]  ld_count;
  logic [3:0]  st_count;

  int checks = 0;
  int errors = 0;

  // Reference view of the outstanding operations, indexed by returned tag.
  bit       mv [16];
  bit       ms [16];
  bit [3:0] mr [16];

  always #5 clk = ~clk;

  fence_order_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_store(mem_store), .mem_addr(mem_addr),
    .mem_tag(mem_tag), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .ld_count(ld_count), .st_count(st_count)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int n_ld();
    int n = 0;
    for (int i = 0; i < 16; i++) if (mv[i] && !ms[i]) n++;
    return n;
  endfunction

  function automatic int n_st();
    int n = 0;
    for (int i = 0; i < 16; i++) if (mv[i] && ms[i]) n++;
    return n;
  endfunction

  function automatic bit rgn_has(bit [3:0] r);
    for (int i = 0; i < 16; i++) if (mv[i] && mr[i] == r) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit fence_ok(bit [2:0] op, bit [3:0] r);
    case (op)
      3'd3: return n_ld() == 0;
      3'd4: return n_st() == 0;
      3'd5: return !rgn_has(r);
      default: return n_ld() == 0 && n_st() == 0;
    endcase
  endfunction

  // One cycle: entered and left at a falling edge.
  task automatic cyc(bit rv, bit [2:0] op, bit [15:0] addr, bit cv, bit [3:0] ctag);
    bit memop, room, exp_rdy, acc;
    bit [3:0] tag;
    req_valid = rv; req_op = op; req_addr = addr;
    cpl_valid = cv; cpl_tag = ctag;
    #1;
    memop = (op <= 3'd1);
    room = (n_ld() + n_st()) < 15;
    acc = 1'b0;
    if (rv) begin
      exp_rdy = memop ? (mem_ready && room) : fence_ok(op, addr[15:12]);
      if (memop)
        chk(req_ready == exp_rdy, room ? "R9 mem op accept" : "R3 full stall",
            req_ready, exp_rdy);
      else
        chk(req_ready == exp_rdy,
            op == 3'd3 ? "R6 load fence" : op == 3'd4 ? "R7 store fence" :
            op == 3'd5 ? "R8 region fence" : "R5 full fence",
            req_ready, exp_rdy);
      chk(mem_valid == (memop && room), memop ? "R2 issue valid" : "R10 fence held off port",
          mem_valid, memop && room);
      if (mem_valid) begin
        chk(mem_addr == addr && mem_store == (op == 3'd1), "R2 forwarded fields",
            mem_addr, addr);
        chk(mem_tag < 15 && !mv[mem_tag], "R2 fresh tag", mem_tag, -1);
      end
      acc = memop && req_ready && mem_valid;
      tag = mem_tag;
    end
    @(posedge clk);
    if (cv && mv[ctag]) mv[ctag] = 1'b0;
    if (acc) begin mv[tag] = 1'b1; ms[tag] = (op == 3'd1); mr[tag] = addr[15:12]; end
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
    #1;
    chk(ld_count == n_ld(), "R4 load count", ld_count, n_ld());
    chk(st_count == n_st(), "R4 store count", st_count, n_st());
  endtask

  task automatic drain();
    for (int t = 0; t < 16; t++) if (mv[t]) cyc(1'b0, 3'd0, 16'h0, 1'b1, 4'(t));
  endtask

  function automatic int tag_of(bit st, bit [3:0] r);
    for (int i = 0; i < 16; i++) if (mv[i] && ms[i] == st && mr[i] == r) return i;
    return 0;
  endfunction

  initial begin
    #(10 * 200000);
    checks++; errors++;
    $display("FAIL watchdog all-reqs actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mv[i] = 0; ms[i] = 0; mr[i] = 0; end
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_addr = 0;
    mem_ready = 1'b1; cpl_valid = 0; cpl_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(ld_count == 0 && st_count == 0, "R1 counts zero", ld_count + st_count, 0);
    chk(mem_valid == 0, "R1 mem idle", mem_valid, 0);
    @(negedge clk);
    cyc(1, 3'd0, 16'h1040, 0, 0);               // R1 first load accepted
    drain();

    // Sweep: every mix of load/store in regions 1 and 2 against every fence.
    for (int p = 0; p < 16; p++) begin
      if (p[0]) cyc(1, 3'd0, 16'h1000, 0, 0);
      if (p[1]) cyc(1, 3'd1, 16'h1004, 0, 0);
      if (p[2]) cyc(1, 3'd0, 16'h2000, 0, 0);
      if (p[3]) cyc(1, 3'd1, 16'h2004, 0, 0);
      for (int op = 2; op < 8; op++) begin
        cyc(1, 3'(op), 16'h1100, 0, 0);
        if (op == 5) begin
          cyc(1, 3'd5, 16'h2100, 0, 0);
          cyc(1, 3'd5, 16'h3100, 0, 0);        // R8 empty region
        end
      end
      drain();
    end

    // R3 fill to 15, then one more is stalled; R9 back-to-back accepts.
    for (int i = 0; i < 15; i++) cyc(1, 3'(i % 2), 16'(16'h4000 + i * 4), 0, 0);
    cyc(1, 3'd0, 16'h4100, 0, 0);
    cyc(1, 3'd1, 16'h4104, 0, 0);
    // R3 completion and blocked issue in the same cycle, then room again
    cyc(1, 3'd0, 16'h4108, 1, 4'd3);
    cyc(1, 3'd0, 16'h4108, 0, 0);
    // R4 unknown tag ignored (tag 15 never allocated)
    cyc(0, 3'd0, 16'h0, 1, 4'd15);
    drain();
    cyc(0, 3'd0, 16'h0, 1, 4'd2);              // R4 completion for idle tag

    // mem_ready low: nothing taken
    mem_ready = 1'b0;
    cyc(1, 3'd1, 16'h5000, 0, 0);
    mem_ready = 1'b1;

    // R10 producer: data store, store fence, pointer store.
    cyc(1, 3'd1, 16'h6000, 0, 0);
    cyc(1, 3'd4, 16'h6000, 0, 0);              // held: data outstanding
    cyc(1, 3'd4, 16'h6000, 1, 4'(tag_of(1, 4'h6)));  // still held this cycle
    cyc(1, 3'd4, 16'h6000, 0, 0);              // retires now
    cyc(1, 3'd1, 16'h6ffc, 0, 0);              // pointer store goes out
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule